// File: doc/BRIEF.md
# Byte-Iterative Hexadecimal Float Multiplier

This execution unit multiplies two floating-point numbers held in a base-16 format: a sign bit, a seven-bit exponent stored with a bias of 64, and a fraction of hex digits. A short operand has 6 hex digits (24 bits) and a long operand has 14 (56 bits). Both operands are captured together from two 64-bit input buses on a single load cycle. The result is then produced on a 64-bit output bus, where it stays until the next load.

Short operands go through a full 3x3 array of byte multipliers. The partial products are registered in one cycle and summed in the next. Long operands reuse a single row of seven byte multipliers. Each cycle, every byte of the first fraction is multiplied by one byte of the second, least significant byte first. The summed row is added to an accumulator that shifts right by one byte per step. Seven multiply cycles and one final accumulation cycle give the exact 112-bit product.

Post-normalization and exponent correction are combinational in the cycle the result is driven out. The result is truncated, never rounded. Overflow and underflow are reported on status outputs.

Top module: `hexfloat_mul`

## Requirements
- R1: After reset, `done`, `busy`, `ovf`, `unf` and `res` are all zero.
- R2: For nonzero fractions the result sign is the XOR of bit 63 of both operands. The result exponent (bits 62:56) is ea + eb - 64, reduced by one when R3 applies. The fraction is the top digits of the product, truncated.
- R3: If the leading hex digit of the fraction product is zero, the fraction is taken one hex digit (4 bits) further down. The exponent is then reduced by one. This shift happens at most once.
- R4: With `dbl`=0, only fraction bits 55:32 of each operand are used, and operand bits 31:0 have no effect. Result bits 31:0 are zero. `done` rises on the second rising edge after the edge that accepts the load.
- R5: With `dbl`=1, fraction bits 55:0 are used and the full product is formed exactly before truncation. `done` rises on the eighth rising edge after the accepting edge.
- R6: If either operand's fraction is zero (bits 55:32 when short, 55:0 when long), the result is all zero and neither flag is set.
- R7: If the corrected exponent exceeds 127, `ovf` is set and the result carries the low seven bits of that exponent.
- R8: If the corrected exponent is below 0, `unf` is set and the result is all zero.
- R9: `load` is accepted only while `busy` is low. `busy` is high from the accepting edge until `done` rises. A `load` asserted while `busy` is high is ignored. `res`, `ovf` and `unf` hold their values while `done` is high until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture both operands and start a multiply |
| dbl | input | 1 | 1 = long (56-bit fraction), 0 = short (24-bit fraction) |
| opa | input | 64 | First operand bus |
| opb | input | 64 | Second operand bus |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Result valid on `res` |
| res | output | 64 | Product, zero while `done` is low |
| ovf | output | 1 | Exponent overflow, valid with `done` |
| unf | output | 1 | Exponent underflow, valid with `done` |

## Verification
The bench builds the unit with the default bias of 64. With this bias, random exponents over the full 0 to 127 range push the corrected exponent both above 127 and below 0, so both flags are reached without directed tuning. Random long fractions exercise every byte of the seven-row accumulation, including carries across the shifted accumulator. Forced leading zero digits cover the single normalization shift. Random low words on short operands, and a load injected mid-operation, cover the inputs that must have no effect.

// File: rtl/hexfloat_mul.sv
module hexfloat_mul #(
  parameter int BIAS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        dbl,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic        busy,
  output logic        done,
  output logic [63:0] res,
  output logic        ovf,
  output logic        unf
);
  localparam int FWS = 24;
  localparam int FWD = 56;
  localparam int NBS = FWS / 8;
  localparam int NBD = FWD / 8;
  localparam int PW  = 2 * FWD;
  localparam int SOFF = (FWD - FWS) / 8;

  typedef enum logic [2:0] {S_IDLE, S_SP1, S_SP2, S_DP, S_DONE} st_t;

  st_t          st;
  logic [63:0]  ra, rb;
  logic         dbl_q;
  logic [2:0]   cnt;
  logic [PW-1:0] acc;
  logic [15:0]  pps [NBS*NBS];
  logic [15:0]  ppd [NBD];
  logic [15:0]  mul_s [NBS*NBS];
  logic [15:0]  mul_d [NBD];
  logic [2*FWS-1:0] ssum;
  logic [FWD+7:0]   rsum;
  logic [7:0]   bsel;

  assign busy = (st == S_SP1) || (st == S_SP2) || (st == S_DP);
  assign done = (st == S_DONE);
  assign bsel = rb[8*cnt +: 8];

  genvar gi, gj;
  generate
    for (gi = 0; gi < NBS; gi++) begin : g_srow
      for (gj = 0; gj < NBS; gj++) begin : g_scol
        assign mul_s[gi*NBS+gj] = ra[8*(SOFF+gi) +: 8] * rb[8*(SOFF+gj) +: 8];
      end
    end
    for (gi = 0; gi < NBD; gi++) begin : g_drow
      assign mul_d[gi] = ra[8*gi +: 8] * bsel;
    end
  endgenerate

  always_comb begin
    ssum = '0;
    for (int i = 0; i < NBS; i++)
      for (int j = 0; j < NBS; j++)
        ssum = ssum + ({{(2*FWS-16){1'b0}}, pps[i*NBS+j]} << (8*(i+j)));
  end

  always_comb begin
    rsum = '0;
    for (int i = 0; i < NBD; i++)
      rsum = rsum + ({{(FWD-8){1'b0}}, ppd[i]} << (8*i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ra    <= '0;
      rb    <= '0;
      dbl_q <= 1'b0;
      cnt   <= '0;
      acc   <= '0;
      for (int i = 0; i < NBS*NBS; i++) pps[i] <= '0;
      for (int i = 0; i < NBD; i++) ppd[i] <= '0;
    end else begin
      case (st)
        S_SP1: begin
          for (int i = 0; i < NBS*NBS; i++) pps[i] <= mul_s[i];
          st <= S_SP2;
        end
        S_SP2: begin
          acc <= {ssum, {(PW-2*FWS){1'b0}}};
          st  <= S_DONE;
        end
        S_DP: begin
          if (cnt < 3'(NBD))
            for (int i = 0; i < NBD; i++) ppd[i] <= mul_d[i];
          if (cnt != 3'd0)
            acc <= (acc >> 8) + ({{(PW-FWD-8){1'b0}}, rsum} << (PW-FWD-8));
          if (cnt == 3'(NBD)) st <= S_DONE;
          cnt <= cnt + 3'd1;
        end
        default: begin
          if (load) begin
            ra    <= opa;
            rb    <= opb;
            dbl_q <= dbl;
            cnt   <= '0;
            acc   <= '0;
            st    <= dbl ? S_DP : S_SP1;
          end
        end
      endcase
    end
  end

  logic        fz, sh, xovf, xunf;
  logic signed [9:0] ex;
  logic [FWD-1:0] frac;
  logic [63:0] rval;

  assign fz = dbl_q ? (ra[FWD-1:0] == '0 || rb[FWD-1:0] == '0)
                    : (ra[FWD-1 -: FWS] == '0 || rb[FWD-1 -: FWS] == '0);
  assign sh = (acc[PW-1 -: 4] == 4'h0);
  assign ex = 10'(ra[62:56]) + 10'(rb[62:56]) - 10'(BIAS) - 10'(sh);
  assign xovf = ex > 10'sd127;
  assign xunf = ex < 10'sd0;

  always_comb begin
    frac = sh ? acc[PW-5 -: FWD] : acc[PW-1 -: FWD];
    if (!dbl_q) frac[FWD-FWS-1:0] = '0;
  end

  assign rval = (fz || xunf) ? 64'd0 : {ra[63] ^ rb[63], ex[6:0], frac};
  assign res  = done ? rval : 64'd0;
  assign ovf  = done && !fz && xovf;
  assign unf  = done && !fz && xunf;
endmodule

// File: rtl/hexfloat_mul_chk.sv
module hexfloat_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic        dbl,
  input logic        busy,
  input logic        done,
  input logic [63:0] res,
  input logic        ovf,
  input logic        unf,
  input logic        mode
);
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_short_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && !dbl) |=> !done ##1 !done ##1 done);

  p_long_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && dbl) |-> ##9 done);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (done && $stable(res) && $stable(ovf) && $stable(unf)));

  p_underflow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> (res == 64'd0));

  p_short_low_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode) |-> (res[31:0] == 32'd0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  p_flags_need_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!ovf && !unf && res == 64'd0));
endmodule

bind hexfloat_mul hexfloat_mul_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .dbl(dbl), .busy(busy),
  .done(done), .res(res), .ovf(ovf), .unf(unf), .mode(dbl_q)
);

// File: tb/tb_hexfloat_mul.sv
module tb_hexfloat_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic dbl = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic busy, done, ovf, unf;
  logic [63:0] res;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hexfloat_mul dut (.clk(clk), .rst_n(rst_n), .load(load), .dbl(dbl),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .res(res), .ovf(ovf), .unf(unf));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [65:0] ref_mul(logic [63:0] a, logic [63:0] b, logic d);
    logic [55:0] fa, fb, fr;
    logic [111:0] p;
    logic s;
    int e;
    fa = d ? a[55:0] : {a[55:32], 32'd0};
    fb = d ? b[55:0] : {b[55:32], 32'd0};
    if (fa == 0 || fb == 0) return 66'd0;
    p = fa * fb;
    s = (p[111:108] == 4'h0);
    fr = s ? p[107:52] : p[111:56];
    if (!d) fr[31:0] = '0;
    e = int'(a[62:56]) + int'(b[62:56]) - 64 - (s ? 1 : 0);
    if (e < 0) return {1'b0, 1'b1, 64'd0};
    return {e > 127, 1'b0, a[63] ^ b[63], 7'(e), fr};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(logic [63:0] a, logic [63:0] b, logic d, bit inj, string tag);
    logic [65:0] ex;
    int lat;
    ex = ref_mul(a, b, d);
    @(negedge clk); opa = a; opb = b; dbl = d; load = 1'b1;
    @(negedge clk); load = 1'b0; lat = 1;
    check("R9 busy after load", {63'd0, busy}, 64'd1);
    if (inj) begin
      opa = ~a; opb = a; dbl = ~d; load = 1'b1;
      @(negedge clk); load = 1'b0; lat++;
    end
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check(d ? "R5 latency" : "R4 latency", 64'(lat), d ? 64'd9 : 64'd3);
    check(tag, res, ex[63:0]);
    check({tag, " flags"}, {62'd0, ovf, unf}, {62'd0, ex[65:64]});
  endtask

  function automatic logic [63:0] rnd_op(bit d);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 4)
      0: v[55:52] = 4'h0;
      1: v[55:52] = 4'hF;
      default: ;
    endcase
    if (v[55:52] == 4'h0 && v[51:48] == 4'h0) v[51:48] = 4'h3;
    if (!d && v[55:32] == 0) v[40] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5eed_1983));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {busy, done, ovf, unf, 60'd0}, 64'd0);
    check("R1 reset res", res, 64'd0);

    run(64'h4110_0000_0000_0000, 64'h4110_0000_0000_0000, 1'b0, 0, "R3 short one*one");
    run(64'h4110_0000_0000_0000, 64'hC120_0000_0000_0000, 1'b1, 0, "R2 long sign");
    run(64'h42FF_FFFF_FFFF_FFFF, 64'h40FF_FFFF_FFFF_FFFF, 1'b1, 0, "R5 long all ones");
    run(64'h4180_0000_DEAD_BEEF, 64'h4180_0000_1234_5678, 1'b0, 0, "R4 short low word ignored");
    run(64'h4100_0000_FFFF_FFFF, 64'h4123_4567_0000_0000, 1'b0, 0, "R6 short zero fraction");
    run(64'hC100_0000_0000_0000, 64'h4712_3456_789A_BCDE, 1'b1, 0, "R6 long zero");
    run(64'h7F80_0000_0000_0000, 64'h7F80_0000_0000_0000, 1'b1, 0, "R7 overflow");
    run(64'h0180_0000_0000_0000, 64'h0180_0000_0000_0000, 1'b0, 0, "R8 underflow");
    run(64'h2010_0000_0000_0000, 64'h2010_0000_0000_0000, 1'b1, 0, "R8 underflow by shift");
    run(64'h4312_3456_789A_BCDE, 64'h3FAB_CDEF_0123_4567, 1'b1, 1, "R9 load while busy ignored");
    run(64'h4312_3456_0000_0000, 64'h3FAB_CDEF_0000_0000, 1'b0, 1, "R9 short load while busy");

    held = res;
    repeat (3) @(negedge clk);
    check("R9 result held", res, held);
    check("R9 done held", {63'd0, done}, 64'd1);

    for (int i = 0; i < 60; i++) begin
      bit d;
      d = ($urandom % 2) == 1;
      run(rnd_op(d), rnd_op(d), d, 0, d ? "R2 random long" : "R2 random short");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule